// File: doc/BRIEF.md
# Snooped PCI Read Line Buffer Controller

This block serves reads that the PCI side makes into local memory, through a single line buffer of 32 bytes held as four 64-bit beats. When a read misses the buffer, the block fetches the whole line that contains the requested address. It raises the memory read and the cache snoop in the same cycle. If the snoop reports that the processor cache holds the line, the memory read is cancelled and the line is refilled from the copyback flush path. If the snoop misses, the memory beats are kept. The PCI side is offered each beat as soon as it lands in the buffer, from the requested beat up to the end of the line.

The block also classifies every access presented on the PCI request port. It compares the access against three line tags: its own read line buffer, the copyback buffer and the posted write buffer. From that comparison it states whether the access must be snooped. Locked reads and copyback hits force a snoop, and hits in the posted buffers skip it. When snooping is turned off, the block never snoops and never cancels.

Top module: `pci_rdline_ctl`

## Requirements
- R1: After reset, `pci_req_ready` is 1 and `pci_rd_valid`, `mem_rd_valid`, `snp_req` and `mem_cancel` are 0.
- R2: A read that must be fetched raises `mem_rd_valid` in the cycle after acceptance, with `mem_rd_addr` equal to the line base (bits [4:0] zero). If a snoop is due, `snp_req` is raised in the same cycle the memory request is taken, with `snp_addr` equal to `mem_rd_addr`. While `mem_rd_ready` is 0, no snoop is issued.
- R3: A snoop response with hit set pulses `mem_cancel` in that same cycle. Memory beats that arrive in or after that cycle are dropped. The line is then rebuilt from the copyback flush beats, which arrive in beat order 0 to 3, and the PCI side receives that data.
- R4: On a snoop miss, all four beats of the line are stored, even when the start address is not line aligned. The PCI side receives the beats from the start beat (address bits [4:3]) through beat 3, and `pci_rd_last` is set on beat 3.
- R5: A beat that is written at a clock edge is offered on `pci_rd_valid` from the next cycle, provided the snoop has been answered. No beat is offered while a snoop is outstanding.
- R6: A non-locked read gives `acc_snoop_need` = 0 when it hits the read line buffer or the write buffer and does not hit the copyback buffer. It gives 1 when it hits the copyback buffer or hits no buffer. A hit is a match of address bits [31:5] against a valid tag. A non-locked read that hits the read line buffer and needs no snoop is served from the buffer with no memory request, and its first beat is offered in the cycle after acceptance.
- R7: A locked read always gives `acc_snoop_need` = 1 and is always fetched again from memory. On a write, the lock flag has no effect.
- R8: A write gives `acc_snoop_need` = 1 when it hits the copyback buffer or the read line buffer, or when it hits no buffer. It gives 0 when it hits only the write buffer. An accepted write that hits the read line buffer invalidates it, so the next read of that line fetches from memory.
- R9: With `snoop_en` = 0, `acc_snoop_need` is 0 and `snp_req` never rises. The memory read still goes ahead, and each beat is offered in the cycle after it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snoop_en | input | 1 | Enables snooping of PCI accesses |
| pci_req_valid | input | 1 | PCI access presented |
| pci_req_ready | output | 1 | Access accepted this cycle if valid (block idle) |
| pci_req_addr | input | 29 | Access address bits [31:3] |
| pci_req_write | input | 1 | 1 = write, 0 = read |
| pci_req_lock | input | 1 | Access opens a locked transfer |
| acc_snoop_need | output | 1 | Presented access must be snooped |
| cb_tag_valid | input | 1 | Copyback buffer holds a line |
| cb_tag | input | 27 | Copyback buffer line address [31:5] |
| wb_tag_valid | input | 1 | Posted write buffer holds a line |
| wb_tag | input | 27 | Posted write buffer line address [31:5] |
| pci_rd_valid | output | 1 | Read beat available |
| pci_rd_ready | input | 1 | PCI side takes the beat |
| pci_rd_data | output | 64 | Read beat data |
| pci_rd_last | output | 1 | Beat is the last of the line |
| mem_rd_valid | output | 1 | Line read request to memory |
| mem_rd_ready | input | 1 | Memory interface free; request taken |
| mem_rd_addr | output | 32 | Line base address |
| mem_cancel | output | 1 | Cancel the outstanding line read |
| mem_beat_valid | input | 1 | Memory beat delivered |
| mem_beat_data | input | 64 | Memory beat data |
| snp_req | output | 1 | Snoop request to the cache side |
| snp_addr | output | 32 | Snooped line address |
| snp_rsp_valid | input | 1 | Snoop response |
| snp_rsp_hit | input | 1 | Snoop hit in the cache |
| cb_beat_valid | input | 1 | Copyback flush beat delivered |
| cb_beat_data | input | 64 | Copyback flush beat data |

## Verification
The snoop decision is combinational, so it is read 1 ns after the access fields settle. The line request and the snoop request appear one register after acceptance, and the bench reads them at the falling edge right after the accepting edge. A beat written at one rising edge is offered at the following falling edge. The scoreboard monitor pops its expected beat only at falling edges where valid and ready are both high, which is exactly where the transfer at the next rising edge is decided. Because of this, the data order, the last flag and the snoop gating are all checked one registered stage after the stimulus that causes them.

// File: rtl/prl_pkg.sv
// Shared types for the snooped PCI read line buffer controller.
package prl_pkg;
    // Sequencer states: idle, request launch, line fill, stream from buffer.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_FILL   = 2'd2,
        ST_STREAM = 2'd3
    } prl_state_e;
endpackage

// File: rtl/prl_snoop_policy.sv
// Snoop decision for a presented PCI access.
// Compares the access line address against the three buffer tags and
// decides whether a snoop is required. Purely combinational.
// Assumes tags are line addresses (bits above the line offset).
module prl_snoop_policy #(
    parameter int TAG_W = 27
) (
    input  logic             snoop_en,
    input  logic [TAG_W-1:0] acc_tag,
    input  logic             acc_write,
    input  logic             acc_lock,
    input  logic             rlb_valid,
    input  logic [TAG_W-1:0] rlb_tag,
    input  logic             cb_valid,
    input  logic [TAG_W-1:0] cb_tag,
    input  logic             wb_valid,
    input  logic [TAG_W-1:0] wb_tag,
    output logic             rlb_hit,
    output logic             need
);
    logic cb_hit;
    logic wb_hit;
    logic rd_need;
    logic wr_need;

    // Tag comparison against each buffer.
    always_comb begin
        rlb_hit = rlb_valid && (rlb_tag == acc_tag);
        cb_hit  = cb_valid  && (cb_tag  == acc_tag);
        wb_hit  = wb_valid  && (wb_tag  == acc_tag);
    end

    // Read and write rules; lock only matters on reads.
    always_comb begin
        rd_need = acc_lock || cb_hit || !(rlb_hit || wb_hit);
        wr_need = cb_hit || rlb_hit || !wb_hit;
        need    = snoop_en && (acc_write ? wr_need : rd_need);
    end
endmodule

// File: rtl/prl_line_store.sv
// Line data store: BEATS data registers with a per-beat valid flag.
// One write port, one read port; a clear drops every valid flag.
// Assumes clear and write are never asserted in the same cycle.
module prl_line_store #(
    parameter int BEATS  = 4,
    parameter int DATA_W = 64,
    localparam int BEAT_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [BEAT_W-1:0] widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BEAT_W-1:0] ridx,
    output logic [DATA_W-1:0] rdata,
    output logic [BEATS-1:0]  bvalid
);
    logic [DATA_W-1:0] data_q [BEATS];

    for (genvar g = 0; g < BEATS; g++) begin : g_beat
        // Per-beat valid flag and data register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bvalid[g] <= 1'b0;
                data_q[g] <= '0;
            end else if (clr) begin
                bvalid[g] <= 1'b0;
            end else if (we && (widx == BEAT_W'(g))) begin
                bvalid[g] <= 1'b1;
                data_q[g] <= wdata;
            end
        end
    end

    // Read port.
    assign rdata = data_q[ridx];
endmodule

// File: rtl/prl_seq.sv
// Sequencer for the line buffer: accepts PCI accesses, launches the line
// read and the snoop together, cancels memory on a snoop hit and switches
// the fill source to the copyback flush, and streams beats to PCI.
// Assumes fill beats arrive in ascending beat order and that a snoop is
// answered exactly once per launched snoop.
module prl_seq
    import prl_pkg::*;
#(
    parameter int BEATS = 4,
    parameter int TAG_W = 27,
    localparam int BEAT_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snoop_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [BEAT_W-1:0] req_beat,
    input  logic              need,
    input  logic              rlb_hit,
    output logic              req_ready,
    output logic              line_valid,
    output logic [TAG_W-1:0]  line_tag,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic              mem_cancel,
    input  logic              mem_beat_valid,
    output logic              snp_req,
    input  logic              snp_rsp_valid,
    input  logic              snp_rsp_hit,
    input  logic              cb_beat_valid,
    output logic              st_clr,
    output logic              st_we,
    output logic [BEAT_W-1:0] st_widx,
    output logic              src_cb,
    input  logic [BEATS-1:0]  st_bvalid,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic              rd_last,
    output logic [BEAT_W-1:0] rd_idx
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    prl_state_e        state;
    logic              do_snp;
    logic              snp_pend;
    logic [BEAT_W-1:0] wr_ptr;
    logic [BEAT_W-1:0] rd_ptr;

    logic idle;
    logic accept_rd;
    logic accept_wr;
    logic serve_buf;
    logic hit_evt;
    logic miss_evt;
    logic forwarding;
    logic rd_fire;

    // Event decode from state and handshakes.
    always_comb begin
        idle       = (state == ST_IDLE);
        accept_rd  = idle && req_valid && !req_write;
        accept_wr  = idle && req_valid && req_write;
        serve_buf  = rlb_hit && !need;
        hit_evt    = (state == ST_FILL) && snp_pend && snp_rsp_valid && snp_rsp_hit;
        miss_evt   = (state == ST_FILL) && snp_pend && snp_rsp_valid && !snp_rsp_hit;
        forwarding = (state == ST_FILL) || (state == ST_STREAM);
    end

    // Port-side outputs.
    always_comb begin
        req_ready    = idle;
        mem_rd_valid = (state == ST_LAUNCH);
        snp_req      = (state == ST_LAUNCH) && do_snp && snoop_en && mem_rd_ready;
        mem_cancel   = hit_evt;
        rd_valid     = forwarding && !snp_pend && st_bvalid[rd_ptr];
        rd_fire      = rd_valid && rd_ready;
        rd_last      = (rd_ptr == LAST_BEAT);
        rd_idx       = rd_ptr;
    end

    // Line store controls.
    always_comb begin
        st_clr  = (accept_rd && !serve_buf) || hit_evt;
        st_we   = (state == ST_FILL) && !hit_evt && (src_cb ? cb_beat_valid : mem_beat_valid);
        st_widx = wr_ptr;
    end

    // State register and transfer bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            do_snp   <= 1'b0;
            snp_pend <= 1'b0;
            src_cb   <= 1'b0;
            wr_ptr   <= '0;
            rd_ptr   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept_rd) begin
                        rd_ptr <= req_beat;
                        if (serve_buf) begin
                            state <= ST_STREAM;
                        end else begin
                            state  <= ST_LAUNCH;
                            do_snp <= need;
                            src_cb <= 1'b0;
                            wr_ptr <= '0;
                        end
                    end
                end
                ST_LAUNCH: begin
                    if (mem_rd_ready) begin
                        state    <= ST_FILL;
                        snp_pend <= do_snp && snoop_en;
                    end
                end
                ST_FILL: begin
                    if (hit_evt) begin
                        snp_pend <= 1'b0;
                        src_cb   <= 1'b1;
                        wr_ptr   <= '0;
                    end else begin
                        if (miss_evt) begin
                            snp_pend <= 1'b0;
                        end
                        if (st_we) begin
                            wr_ptr <= wr_ptr + 1'b1;
                        end
                    end
                    if (rd_fire) begin
                        rd_ptr <= rd_ptr + 1'b1;
                        if (rd_last) begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_STREAM: begin
                    if (rd_fire) begin
                        rd_ptr <= rd_ptr + 1'b1;
                        if (rd_last) begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Line tag and whole-line valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_valid <= 1'b0;
            line_tag   <= '0;
        end else begin
            if (accept_rd && !serve_buf) begin
                line_valid <= 1'b0;
                line_tag   <= req_tag;
            end else if (accept_wr && rlb_hit) begin
                line_valid <= 1'b0;
            end else if (hit_evt) begin
                line_valid <= 1'b0;
            end else if (st_we && (wr_ptr == LAST_BEAT)) begin
                line_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pci_rdline_ctl.sv
// Top of the snooped PCI read line buffer controller.
// Wires the snoop policy, the sequencer and the line store together.
// Assumes the address port carries bits [ADDR_W-1:3] of a byte address and
// that both fill sources deliver one line as BEATS ascending beats.
module pci_rdline_ctl #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int LINE_BYTES = 32,
    localparam int BYTE_OFF  = $clog2(DATA_W / 8),
    localparam int LINE_OFF  = $clog2(LINE_BYTES),
    localparam int BEATS     = LINE_BYTES / (DATA_W / 8),
    localparam int BEAT_W    = $clog2(BEATS),
    localparam int TAG_W     = ADDR_W - LINE_OFF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   snoop_en,
    input  logic                   pci_req_valid,
    output logic                   pci_req_ready,
    input  logic [ADDR_W-1:BYTE_OFF] pci_req_addr,
    input  logic                   pci_req_write,
    input  logic                   pci_req_lock,
    output logic                   acc_snoop_need,
    input  logic                   cb_tag_valid,
    input  logic [TAG_W-1:0]       cb_tag,
    input  logic                   wb_tag_valid,
    input  logic [TAG_W-1:0]       wb_tag,
    output logic                   pci_rd_valid,
    input  logic                   pci_rd_ready,
    output logic [DATA_W-1:0]      pci_rd_data,
    output logic                   pci_rd_last,
    output logic                   mem_rd_valid,
    input  logic                   mem_rd_ready,
    output logic [ADDR_W-1:0]      mem_rd_addr,
    output logic                   mem_cancel,
    input  logic                   mem_beat_valid,
    input  logic [DATA_W-1:0]      mem_beat_data,
    output logic                   snp_req,
    output logic [ADDR_W-1:0]      snp_addr,
    input  logic                   snp_rsp_valid,
    input  logic                   snp_rsp_hit,
    input  logic                   cb_beat_valid,
    input  logic [DATA_W-1:0]      cb_beat_data
);
    logic [TAG_W-1:0]  acc_tag;
    logic [BEAT_W-1:0] acc_beat;
    logic              rlb_hit;
    logic              line_valid;
    logic [TAG_W-1:0]  line_tag;
    logic              st_clr;
    logic              st_we;
    logic [BEAT_W-1:0] st_widx;
    logic              src_cb;
    logic [DATA_W-1:0] st_wdata;
    logic [BEATS-1:0]  st_bvalid;
    logic [BEAT_W-1:0] rd_idx;

    // Split the access address into line tag and beat index.
    assign acc_tag  = pci_req_addr[ADDR_W-1:LINE_OFF];
    assign acc_beat = pci_req_addr[LINE_OFF-1:BYTE_OFF];

    // Fill source select and line base address.
    assign st_wdata    = src_cb ? cb_beat_data : mem_beat_data;
    assign mem_rd_addr = {line_tag, {LINE_OFF{1'b0}}};
    assign snp_addr    = mem_rd_addr;

    prl_snoop_policy #(
        .TAG_W (TAG_W)
    ) u_policy (
        .snoop_en  (snoop_en),
        .acc_tag   (acc_tag),
        .acc_write (pci_req_write),
        .acc_lock  (pci_req_lock),
        .rlb_valid (line_valid),
        .rlb_tag   (line_tag),
        .cb_valid  (cb_tag_valid),
        .cb_tag    (cb_tag),
        .wb_valid  (wb_tag_valid),
        .wb_tag    (wb_tag),
        .rlb_hit   (rlb_hit),
        .need      (acc_snoop_need)
    );

    prl_seq #(
        .BEATS (BEATS),
        .TAG_W (TAG_W)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .snoop_en       (snoop_en),
        .req_valid      (pci_req_valid),
        .req_write      (pci_req_write),
        .req_tag        (acc_tag),
        .req_beat       (acc_beat),
        .need           (acc_snoop_need),
        .rlb_hit        (rlb_hit),
        .req_ready      (pci_req_ready),
        .line_valid     (line_valid),
        .line_tag       (line_tag),
        .mem_rd_valid   (mem_rd_valid),
        .mem_rd_ready   (mem_rd_ready),
        .mem_cancel     (mem_cancel),
        .mem_beat_valid (mem_beat_valid),
        .snp_req        (snp_req),
        .snp_rsp_valid  (snp_rsp_valid),
        .snp_rsp_hit    (snp_rsp_hit),
        .cb_beat_valid  (cb_beat_valid),
        .st_clr         (st_clr),
        .st_we          (st_we),
        .st_widx        (st_widx),
        .src_cb         (src_cb),
        .st_bvalid      (st_bvalid),
        .rd_valid       (pci_rd_valid),
        .rd_ready       (pci_rd_ready),
        .rd_last        (pci_rd_last),
        .rd_idx         (rd_idx)
    );

    prl_line_store #(
        .BEATS  (BEATS),
        .DATA_W (DATA_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (st_clr),
        .we     (st_we),
        .widx   (st_widx),
        .wdata  (st_wdata),
        .ridx   (rd_idx),
        .rdata  (pci_rd_data),
        .bvalid (st_bvalid)
    );
endmodule

// File: rtl/prl_chk.sv
// Protocol checker for pci_rdline_ctl, attached by bind.
// Observes ports only; holds no state of its own.
module prl_chk #(
    parameter int ADDR_W   = 32,
    parameter int LINE_OFF = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              snoop_en,
    input logic              pci_req_valid,
    input logic              pci_req_write,
    input logic              pci_req_lock,
    input logic              pci_req_ready,
    input logic              acc_snoop_need,
    input logic              pci_rd_valid,
    input logic              pci_rd_ready,
    input logic              pci_rd_last,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              mem_cancel,
    input logic              snp_req
);
    // R2: a snoop only goes out together with a taken memory request.
    p_launch_together_r2: assert property (@(posedge clk) disable iff (!rst_n)
        snp_req |-> (mem_rd_valid && mem_rd_ready));

    // R2: the snoop targets the same line base as the memory read.
    p_same_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        snp_req |-> (snp_addr == mem_rd_addr));

    // R2: the memory request is line aligned.
    p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (mem_rd_addr[LINE_OFF-1:0] == '0));

    // R2: a stalled memory request holds its address.
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R3: after a cancel no stale beat is offered.
    p_cancel_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cancel |=> !pci_rd_valid);

    // R4: the last beat ends the transfer.
    p_last_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_rd_valid && pci_rd_ready && pci_rd_last) |=> pci_req_ready);

    // R7: a locked read always demands a snoop while snooping is on.
    p_lock_snoop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_req_valid && !pci_req_write && pci_req_lock && snoop_en) |-> acc_snoop_need);

    // R9: no snoop activity with snooping off.
    p_no_snoop_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !snoop_en |-> (!acc_snoop_need && !snp_req && !mem_cancel));
endmodule

bind pci_rdline_ctl prl_chk #(
    .ADDR_W   (ADDR_W),
    .LINE_OFF (LINE_OFF)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .snoop_en       (snoop_en),
    .pci_req_valid  (pci_req_valid),
    .pci_req_write  (pci_req_write),
    .pci_req_lock   (pci_req_lock),
    .pci_req_ready  (pci_req_ready),
    .acc_snoop_need (acc_snoop_need),
    .pci_rd_valid   (pci_rd_valid),
    .pci_rd_ready   (pci_rd_ready),
    .pci_rd_last    (pci_rd_last),
    .mem_rd_valid   (mem_rd_valid),
    .mem_rd_ready   (mem_rd_ready),
    .mem_rd_addr    (mem_rd_addr),
    .snp_addr       (snp_addr),
    .mem_cancel     (mem_cancel),
    .snp_req        (snp_req)
);

// File: tb/pci_rdline_ctl_tb.sv
// Scoreboard bench for pci_rdline_ctl.
module pci_rdline_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        snoop_en;
    logic        pci_req_valid;
    logic        pci_req_ready;
    logic [31:3] pci_req_addr;
    logic        pci_req_write;
    logic        pci_req_lock;
    logic        acc_snoop_need;
    logic        cb_tag_valid;
    logic [26:0] cb_tag;
    logic        wb_tag_valid;
    logic [26:0] wb_tag;
    logic        pci_rd_valid;
    logic        pci_rd_ready;
    logic [63:0] pci_rd_data;
    logic        pci_rd_last;
    logic        mem_rd_valid;
    logic        mem_rd_ready;
    logic [31:0] mem_rd_addr;
    logic        mem_cancel;
    logic        mem_beat_valid;
    logic [63:0] mem_beat_data;
    logic        snp_req;
    logic [31:0] snp_addr;
    logic        snp_rsp_valid;
    logic        snp_rsp_hit;
    logic        cb_beat_valid;
    logic [63:0] cb_beat_data;

    int checks = 0;
    int errors = 0;
    int launches = 0;
    bit finished = 0;

    logic [63:0] exp_data_q[$];
    logic        exp_last_q[$];

    always #4 clk = ~clk;   // 125 MHz

    pci_rdline_ctl u_dut (.*);

    function automatic logic [63:0] mdat(logic [31:0] line, int b);
        return {line ^ 32'hA5A5_0000, 32'(b)};
    endfunction

    function automatic logic [63:0] cdat(logic [31:0] line, int b);
        return {line ^ 32'h5A5A_0000, 32'(b) ^ 32'hC0DE_0000};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver side: push the beats the PCI side must see.
    task automatic push_line(logic [31:0] line, int start, bit from_cb);
        for (int b = start; b < 4; b++) begin
            exp_data_q.push_back(from_cb ? cdat(line, b) : mdat(line, b));
            exp_last_q.push_back(b == 3);
        end
    endtask

    // Monitor: pop and compare each beat transferred.
    always @(negedge clk) begin
        if (rst_n && mem_rd_valid && mem_rd_ready) launches++;
        if (rst_n && pci_rd_valid && pci_rd_ready) begin
            if (exp_data_q.size() == 0) begin
                chk("R4 unexpected beat", pci_rd_data, 64'hx);
            end else begin
                chk("R4 beat data", pci_rd_data, exp_data_q.pop_front());
                chk("R4 last flag", 64'(pci_rd_last), 64'(exp_last_q.pop_front()));
            end
        end
    end

    task automatic issue(logic [31:0] addr, bit wr, bit lk);
        pci_req_addr  = addr[31:3];
        pci_req_write = wr;
        pci_req_lock  = lk;
        pci_req_valid = 1'b1;
        while (!pci_req_ready) @(negedge clk);
        @(negedge clk);
        pci_req_valid = 1'b0;
        pci_req_lock  = 1'b0;
        pci_req_write = 1'b0;
    endtask

    task automatic mem_beat(logic [63:0] d);
        mem_beat_valid = 1'b1;
        mem_beat_data  = d;
        @(negedge clk);
        mem_beat_valid = 1'b0;
    endtask

    task automatic cb_beat(logic [63:0] d);
        cb_beat_valid = 1'b1;
        cb_beat_data  = d;
        @(negedge clk);
        cb_beat_valid = 1'b0;
    endtask

    task automatic snoop_rsp(bit hit, string req);
        snp_rsp_valid = 1'b1;
        snp_rsp_hit   = hit;
        #1;
        chk(req, 64'(mem_cancel), 64'(hit));
        @(negedge clk);
        snp_rsp_valid = 1'b0;
        snp_rsp_hit   = 1'b0;
    endtask

    task automatic wait_done(string req);
        while (!pci_req_ready) @(negedge clk);
        chk(req, 64'(exp_data_q.size()), 64'd0);
    endtask

    task automatic policy(logic [31:0] addr, bit wr, bit lk, bit exp, string req);
        pci_req_addr  = addr[31:3];
        pci_req_write = wr;
        pci_req_lock  = lk;
        #1;
        chk(req, 64'(acc_snoop_need), 64'(exp));
        pci_req_write = 1'b0;
        pci_req_lock  = 1'b0;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int l0;
        rst_n = 1'b0; snoop_en = 1'b1;
        pci_req_valid = 0; pci_req_addr = '0; pci_req_write = 0; pci_req_lock = 0;
        cb_tag_valid = 0; cb_tag = '0; wb_tag_valid = 0; wb_tag = '0;
        pci_rd_ready = 1; mem_rd_ready = 1; mem_beat_valid = 0; mem_beat_data = '0;
        snp_rsp_valid = 0; snp_rsp_hit = 0; cb_beat_valid = 0; cb_beat_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 req_ready", 64'(pci_req_ready), 64'd1);
        chk("R1 quiet outputs", 64'({pci_rd_valid, mem_rd_valid, snp_req, mem_cancel}), 64'd0);

        // R2/R5: aligned miss, beat held back while snoop pending
        push_line(32'h1040, 0, 0);
        issue(32'h0000_1040, 0, 0);
        #1;
        chk("R2 mem_rd_valid", 64'(mem_rd_valid), 64'd1);
        chk("R2 snp_req same cycle", 64'(snp_req), 64'd1);
        chk("R2 line address", 64'(mem_rd_addr), 64'h1040);
        chk("R2 snoop address", 64'(snp_addr), 64'h1040);
        @(negedge clk);
        mem_beat(mdat(32'h1040, 0));
        chk("R5 no beat while snoop pending", 64'(pci_rd_valid), 64'd0);
        snoop_rsp(0, "R3 no cancel on miss");
        chk("R5 beat offered after snoop", 64'(pci_rd_valid), 64'd1);
        for (int b = 1; b < 4; b++) mem_beat(mdat(32'h1040, b));
        wait_done("R4 aligned line drained");

        // R4: unaligned start, whole line fetched
        push_line(32'h2060, 2, 0);
        issue(32'h0000_2070, 0, 0);
        #1;
        chk("R4 line base for unaligned start", 64'(mem_rd_addr), 64'h2060);
        @(negedge clk);
        snoop_rsp(0, "R3 no cancel on miss");
        mem_beat(mdat(32'h2060, 0));
        chk("R5 start beat not yet offered", 64'(pci_rd_valid), 64'd0);
        mem_beat(mdat(32'h2060, 1));
        mem_beat(mdat(32'h2060, 2));
        chk("R5 beat offered cycle after write", 64'(pci_rd_valid), 64'd1);
        mem_beat(mdat(32'h2060, 3));
        wait_done("R4 unaligned line drained");

        // R6: buffer hit served without memory (proves all four beats stored)
        policy(32'h0000_2068, 0, 0, 0, "R6 read hit line buffer no snoop");
        l0 = launches;
        push_line(32'h2060, 0, 0);
        issue(32'h0000_2060, 0, 0);
        #1;
        chk("R6 first beat cycle after accept", 64'(pci_rd_valid), 64'd1);
        chk("R6 no memory request", 64'(mem_rd_valid), 64'd0);
        wait_done("R6 buffer line drained");
        chk("R6 no launch counted", 64'(launches - l0), 64'd0);

        // R7: locked read refetches
        policy(32'h0000_2060, 0, 1, 1, "R7 locked read snoops");
        push_line(32'h2060, 1, 0);
        issue(32'h0000_2068, 0, 1);
        #1;
        chk("R7 locked read fetches", 64'(mem_rd_valid), 64'd1);
        @(negedge clk);
        snoop_rsp(0, "R3 no cancel on miss");
        for (int b = 0; b < 4; b++) mem_beat(mdat(32'h2060, b));
        wait_done("R7 locked line drained");

        // R3: snoop hit cancels and copyback fills
        push_line(32'h3000, 2, 1);
        issue(32'h0000_3010, 0, 0);
        @(negedge clk);
        mem_beat(mdat(32'h3000, 0));
        snoop_rsp(1, "R3 cancel on hit");
        chk("R3 nothing offered after cancel", 64'(pci_rd_valid), 64'd0);
        mem_beat(64'hDEAD_BEEF_DEAD_BEEF);
        chk("R3 late memory beat dropped", 64'(pci_rd_valid), 64'd0);
        for (int b = 0; b < 4; b++) cb_beat(cdat(32'h3000, b));
        wait_done("R3 copyback line drained");

        // R6/R7/R8: snoop decision table (line buffer holds 0x3000)
        policy(32'h0000_3008, 0, 0, 0, "R6 read hit line buffer");
        cb_tag_valid = 1; cb_tag = 27'(32'h3000 >> 5);
        policy(32'h0000_3008, 0, 0, 1, "R6 read hit copyback");
        cb_tag = 27'(32'h7000 >> 5);
        policy(32'h0000_7000, 1, 0, 1, "R8 write hit copyback");
        cb_tag_valid = 0;
        wb_tag_valid = 1; wb_tag = 27'(32'h5000 >> 5);
        policy(32'h0000_5000, 0, 0, 0, "R6 read hit write buffer");
        policy(32'h0000_5000, 1, 0, 0, "R8 write hit write buffer");
        policy(32'h0000_5000, 1, 1, 0, "R7 lock ignored on write");
        wb_tag_valid = 0;
        policy(32'h0000_6000, 0, 0, 1, "R6 read no hit");
        policy(32'h0000_6000, 1, 0, 1, "R8 write no hit");
        policy(32'h0000_3000, 1, 0, 1, "R8 write hit line buffer");

        // R8: write hit invalidates the line buffer
        issue(32'h0000_3010, 1, 0);
        push_line(32'h3000, 0, 0);
        issue(32'h0000_3000, 0, 0);
        #1;
        chk("R8 read after write refetches", 64'(mem_rd_valid), 64'd1);
        @(negedge clk);
        snoop_rsp(0, "R3 no cancel on miss");
        for (int b = 0; b < 4; b++) mem_beat(mdat(32'h3000, b));
        wait_done("R8 refetched line drained");

        // R9: snooping disabled
        snoop_en = 0;
        policy(32'h0000_6000, 0, 1, 0, "R9 no snoop need when off");
        push_line(32'h6000, 0, 0);
        issue(32'h0000_6000, 0, 0);
        #1;
        chk("R9 memory read proceeds", 64'(mem_rd_valid), 64'd1);
        chk("R9 no snoop request", 64'(snp_req), 64'd0);
        @(negedge clk);
        mem_beat(mdat(32'h6000, 0));
        chk("R9 beat offered cycle after write", 64'(pci_rd_valid), 64'd1);
        for (int b = 1; b < 4; b++) mem_beat(mdat(32'h6000, b));
        wait_done("R9 line drained");
        snoop_en = 1;

        // R2: memory busy holds back the snoop
        mem_rd_ready = 0;
        push_line(32'h8000, 3, 0);
        issue(32'h0000_8018, 0, 0);
        #1;
        chk("R2 request while memory busy", 64'(mem_rd_valid), 64'd1);
        chk("R2 no snoop while memory busy", 64'(snp_req), 64'd0);
        @(negedge clk);
        mem_rd_ready = 1;
        #1;
        chk("R2 snoop with memory free", 64'(snp_req), 64'd1);
        @(negedge clk);
        snoop_rsp(0, "R3 no cancel on miss");
        for (int b = 0; b < 4; b++) mem_beat(mdat(32'h8000, b));
        wait_done("R2 delayed line drained");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule